// File: doc/BRIEF.md
# Cascadable serial-to-parallel output latch

This block turns a serial bit stream into a parallel word that changes only when asked to. Bits enter a shift chain one at a time on rising edges of a shift clock input. A separate store clock input copies the whole chain into a holding register. The holding register drives the parallel output bus. An active-low output enable either drives the bus or leaves it floating.

The last chain stage is brought out as a cascade output, so several blocks can be chained into a wider word. That output stays driven even while the bus floats. An active-low clear input empties the chain at once and leaves the holding register alone.

Both control clocks are treated as strobes. Each is sampled in one system clock domain, and it acts at the first system edge after it rises.

Top module: `sipo_latch`

## Requirements
- R1: After system reset (`rst_n` low), every chain stage and every holding register bit is zero, so an enabled bus reads 0 and `cascade_out` reads 0.
- R2: At the first system clock edge after `shift_clk_in` rises while `clear_n` is high, stage 0 takes `ser_in` and each stage i takes the old value of stage i-1. Stage i is visible as `par_out[i]` after a store, and the last stage is `cascade_out`. Eight shifts of bits v[7] down to v[0] therefore leave the chain equal to v.
- R3: At the first system clock edge after `store_clk_in` rises, all chain stages are copied into the holding register in one step.
- R4: While `clear_n` is low, every chain stage is zero. This takes effect without waiting for a clock edge and overrides any shift strobe.
- R5: `clear_n` has no effect on the holding register. The parallel bus keeps showing the last stored word through a clear.
- R6: With `oe_n` high, all `par_out` bits are high impedance and `par_valid` is 0. With `oe_n` low, `par_out` equals the holding register and `par_valid` is 1.
- R7: `cascade_out` always equals the last chain stage, whatever the level of `oe_n`.
- R8: When shift and store strobes fall on the same system edge (both clocks tied together), the holding register receives the chain contents from before that shift. The stored word therefore lags the chain by one pulse.
- R9: A clock input held high produces exactly one strobe. Without a store strobe the holding register keeps its value, and without a shift strobe (clear high) the chain keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| shift_clk_in | input | 1 | Shift clock; a rising level advances the chain |
| store_clk_in | input | 1 | Store clock; a rising level copies the chain to the holding register |
| clear_n | input | 1 | Asynchronous active-low clear of the chain only |
| oe_n | input | 1 | Active-low enable for the parallel bus |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_out | output | W | Parallel bus from the holding register, Z when disabled |
| par_valid | output | 1 | 1 when the parallel bus is driven |
| cascade_out | output | 1 | Last chain stage, always driven |

## Verification
A shift strobe and a store strobe can land on the same system edge. The bench provokes this by raising both clock inputs in the same cycle, as a board would with the two pins tied. It expects the stored word to be the chain value from before the shift. A clear can also coincide with a shift strobe. The bench raises the shift clock while holding the clear low and expects an empty chain after release. Every check is compared against a bench model driven by the same stimulus.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int STB_SHIFT = 0;
  localparam int STB_STORE = 1;
  localparam int STB_COUNT = 2;
endpackage

// File: rtl/sipo_edge_strobe.sv
module sipo_edge_strobe #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level_in,
  output logic [N-1:0] strobe
);
  logic [N-1:0] level_q;

  for (genvar g = 0; g < N; g++) begin : g_det
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q[g] <= 1'b0;
      else        level_q[g] <= level_in[g];
    end
    assign strobe[g] = level_in[g] & ~level_q[g];
  end
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_n,
  input  logic         step,
  input  logic         ser_in,
  output logic [W-1:0] chain
);
  logic chain_rst_n;
  assign chain_rst_n = rst_n & clear_n;

  function automatic logic [W-1:0] advance(input logic [W-1:0] cur, input logic bit_in);
    return {cur[W-2:0], bit_in};
  endfunction

  always_ff @(posedge clk or negedge chain_rst_n) begin
    if (!chain_rst_n) chain <= '0;
    else if (step)    chain <= advance(chain, ser_in);
  end
endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sipo_latch.sv
module sipo_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_clk_in,
  input  logic         store_clk_in,
  input  logic         clear_n,
  input  logic         oe_n,
  input  logic         ser_in,
  output logic [W-1:0] par_out,
  output logic         par_valid,
  output logic         cascade_out
);
  import sipo_pkg::*;

  logic [STB_COUNT-1:0] clk_levels;
  logic [STB_COUNT-1:0] strobes;
  logic                 shift_stb;
  logic                 store_stb;
  logic [W-1:0]         chain_q;
  logic [W-1:0]         hold_q;

  assign clk_levels[STB_SHIFT] = shift_clk_in;
  assign clk_levels[STB_STORE] = store_clk_in;

  sipo_edge_strobe #(.N(STB_COUNT)) u_strobe (
    .clk(clk), .rst_n(rst_n), .level_in(clk_levels), .strobe(strobes)
  );

  assign shift_stb = strobes[STB_SHIFT];
  assign store_stb = strobes[STB_STORE];

  sipo_shift_chain #(.W(W)) u_chain (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .step(shift_stb),
    .ser_in(ser_in), .chain(chain_q)
  );

  sipo_hold_reg #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(store_stb), .d(chain_q), .q(hold_q)
  );

  assign par_valid   = ~oe_n;
  assign par_out     = oe_n ? {W{1'bz}} : hold_q;
  assign cascade_out = chain_q[W-1];
endmodule

// File: rtl/sipo_latch_props.sv
module sipo_latch_props #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear_n,
  input logic         oe_n,
  input logic         ser_in,
  input logic         shift_stb,
  input logic         store_stb,
  input logic [W-1:0] chain,
  input logic [W-1:0] hold,
  input logic [W-1:0] par_out,
  input logic         par_valid,
  input logic         cascade_out
);
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && clear_n) |=> (!clear_n || chain == {$past(chain[W-2:0]), $past(ser_in)}));

  assert_store_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb |=> (hold == $past(chain)));

  assert_clear_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> (chain == '0));

  assert_oe_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |-> (par_out === hold));

  assert_cascade_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_out == chain[W-1]);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !store_stb |=> $stable(hold));

  assert_chain_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_stb && clear_n) |=> (!clear_n || $stable(chain)));
endmodule

bind sipo_latch sipo_latch_props #(.W(W)) u_props (
  .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .oe_n(oe_n), .ser_in(ser_in),
  .shift_stb(shift_stb), .store_stb(store_stb), .chain(chain_q), .hold(hold_q),
  .par_out(par_out), .par_valid(par_valid), .cascade_out(cascade_out)
);

// File: tb/sipo_latch_test.sv
module sipo_latch_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_clk_in = 1'b0;
  logic         store_clk_in = 1'b0;
  logic         clear_n = 1'b1;
  logic         oe_n = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_out;
  logic         par_valid;
  logic         cascade_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] m_chain = '0;
  logic [W-1:0] m_hold = '0;

  always #2 clk = ~clk;

  sipo_latch #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .shift_clk_in(shift_clk_in), .store_clk_in(store_clk_in),
    .clear_n(clear_n), .oe_n(oe_n), .ser_in(ser_in), .par_out(par_out),
    .par_valid(par_valid), .cascade_out(cascade_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    ser_in = b;
    shift_clk_in = 1'b1;
    @(negedge clk);
    shift_clk_in = 1'b0;
    m_chain = {m_chain[W-2:0], b};
  endtask

  task automatic store();
    @(negedge clk);
    store_clk_in = 1'b1;
    @(negedge clk);
    store_clk_in = 1'b0;
    m_hold = m_chain;
  endtask

  task automatic tied_pulse(input logic b);
    @(negedge clk);
    ser_in = b;
    shift_clk_in = 1'b1;
    store_clk_in = 1'b1;
    @(negedge clk);
    shift_clk_in = 1'b0;
    store_clk_in = 1'b0;
    m_hold = m_chain;
    m_chain = {m_chain[W-2:0], b};
  endtask

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bus after reset", par_out, 0);
    chk("R1 cascade after reset", cascade_out, 0);
    chk("R6 valid when enabled", par_valid, 1);

    for (int v = 0; v < 256; v++) begin
      for (int i = W - 1; i >= 0; i--) shift_bit(v[i]);
      chk("R2 cascade is last stage", cascade_out, v[W-1]);
      store();
      chk("R3 stored word", par_out, v);
    end

    shift_bit(1'b0);
    chk("R9 bus holds without store", par_out, m_hold);
    chk("R2 model chain tail", cascade_out, m_chain[W-1]);

    @(negedge clk);
    shift_clk_in = 1'b1;
    ser_in = 1'b1;
    repeat (5) @(negedge clk);
    shift_clk_in = 1'b0;
    m_chain = {m_chain[W-2:0], 1'b1};
    store();
    chk("R9 held level shifts once", par_out, m_chain);

    for (int k = 0; k < 20; k++) begin
      tied_pulse(logic'((k * 5 + 3) % 3 == 0));
      chk("R8 tied clocks lag", par_out, m_hold);
    end
    store();
    chk("R8 final catch-up", par_out, m_chain);

    for (int i = 0; i < W; i++) shift_bit(1'b1);
    store();
    chk("R3 all ones", par_out, {W{1'b1}});
    @(negedge clk);
    clear_n = 1'b0;
    #1;
    chk("R4 clear immediate", cascade_out, 0);
    chk("R5 hold kept through clear", par_out, {W{1'b1}});
    ser_in = 1'b1;
    shift_clk_in = 1'b1;
    @(negedge clk);
    shift_clk_in = 1'b0;
    @(negedge clk);
    chk("R4 clear overrides shift", cascade_out, 0);
    clear_n = 1'b1;
    m_chain = '0;
    @(negedge clk);
    chk("R5 hold after release", par_out, {W{1'b1}});
    store();
    chk("R4 chain empty after clear", par_out, 0);

    for (int i = 0; i < W; i++) shift_bit(logic'(i % 2 == 0));
    store();
    @(negedge clk);
    oe_n = 1'b1;
    #1;
    chk("R6 bus floats", (par_out === {W{1'bz}}) ? 32'd1 : 32'd0, 1);
    chk("R6 valid low", par_valid, 0);
    chk("R7 cascade driven while disabled", cascade_out, m_chain[W-1]);
    shift_bit(1'b1);
    shift_bit(1'b0);
    chk("R7 cascade follows shifts while disabled", cascade_out, m_chain[W-1]);
    @(negedge clk);
    oe_n = 1'b0;
    #1;
    chk("R6 bus returns", par_out, m_hold);
    chk("R6 valid high", par_valid, 1);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bus after second reset", par_out, 0);
    chk("R1 cascade after second reset", cascade_out, 0);
    summary();
  end
endmodule